// File: doc/BRIEF.md
# Latched Fault Supervisor for a Single-Phase Buck Controller

This block sits between the analog fault comparators of a hysteretic buck controller and its gate drivers. Each clock it reads six fault flags: relative over-voltage at 114% of the reference, absolute over-voltage above 2.0 V, core below 86% of the reference, current-limit trip, over-temperature and supply undervoltage. It also reads three status inputs: enable, soft-start finished and voltage transition in progress. From these it decides whether the drivers may switch freely or must be forced into a safe state. All inputs are taken to be already synchronous to `clk`.

A state machine holds the supervisor's condition. `ST_IDLE` means disabled, `ST_UVLO` means a supply is undervoltage, `ST_RUN` means normal switching, and `ST_LATCH_CL`, `ST_LATCH_OV` and `ST_LATCH_OT` are the current-limit, over-voltage and thermal latches. The transitions are:
- enter-uvlo: from any state to `ST_UVLO` when `uvlo` is high.
- disable: from any state to `ST_IDLE` when `en` is low.
- start: from `ST_IDLE` or `ST_UVLO` to `ST_RUN`.
- trip-thermal, trip-ov and trip-cl: from `ST_RUN` into a latch.
- escalate-ov: from `ST_LATCH_CL` to `ST_LATCH_OV`.
- escalate-thermal: from `ST_LATCH_CL` or `ST_LATCH_OV` to `ST_LATCH_OT`.

A separate pulse counter watches the current-limit trip. A registered fault code records the first latched cause.

Top module: `fault_guard`

## Requirements
- R1: In `ST_RUN`, `ovp_rel` causes a latch only while `ss_done`=1 and `trans_active`=0. It then gives `latched_off`=1, `force_bot_on`=1, `force_top_off`=1 and `fault_code`=3. Otherwise `ovp_rel` has no effect.
- R2: In `ST_RUN`, `ovp_abs` latches regardless of `ss_done` and `trans_active`. It gives `latched_off`=1, `force_bot_on`=1, `force_top_off`=1 and `fault_code`=4.
- R3: Each rising edge of `ilim_trip` seen while `core_low`=1 counts one pulse. The 32nd counted pulse latches the block with `force_top_off`=1, `force_bot_on`=0, `force_both_off`=0 and `fault_code`=5. The 31st pulse does not latch.
- R4: The pulse count returns to zero when `core_low` and `ilim_trip` are both low in the same cycle. No pulses are counted while `ss_done`=0.
- R5: `over_temp` latches the block from `ST_RUN`, `ST_LATCH_CL` or `ST_LATCH_OV`. The result is `force_both_off`=1, `force_bot_on`=0, `force_top_off`=0 and `latched_off`=1. Entry from `ST_RUN` sets `fault_code`=2.
- R6: `uvlo` gives `force_both_off`=1, `latched_off`=0 and `fault_code`=1 for as long as it lasts. Once it is removed with `en` high, the block returns to run, with no forced outputs and `fault_code`=0.
- R7: A latched state persists after its fault inputs are removed. Only `en`=0 or `uvlo`=1 clears it. `en`=0 gives `force_both_off`=1, `latched_off`=0 and `fault_code`=0.
- R8: Faults seen together in `ST_RUN` are ranked thermal first, then absolute over-voltage, then relative over-voltage, then current limit. A later over-voltage overrides a current-limit latch and turns the bottom driver on. A later thermal fault overrides either latch. `fault_code` keeps the first cause until the latch is cleared.
- R9: While `rst_n`=0, the outputs show the disabled state: `force_both_off`=1, the other overrides 0, `latched_off`=0 and `fault_code`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Controller enable |
| uvlo | input | 1 | Supply undervoltage flag |
| ss_done | input | 1 | Soft-start has finished |
| trans_active | input | 1 | Voltage code or sleep transition in progress |
| ovp_rel | input | 1 | Core above 114% of reference |
| ovp_abs | input | 1 | Core above 2.0 V |
| core_low | input | 1 | Core below 86% of reference |
| ilim_trip | input | 1 | Current-limit comparator output |
| over_temp | input | 1 | Over-temperature flag |
| fault_code | output | 3 | 0 none, 1 uvlo, 2 thermal, 3 rel-ov, 4 abs-ov, 5 current limit |
| force_top_off | output | 1 | Hold the high-side driver low |
| force_bot_on | output | 1 | Hold the low-side driver high |
| force_both_off | output | 1 | Hold both drivers low |
| latched_off | output | 1 | A latched fault is active |

## Verification
The relative over-voltage flag is applied three ways: with soft-start pending, during a transition, and with the block fully armed. Comparing these separates the arming conditions from the latch itself. The absolute flag is applied during a transition with soft-start pending, which shows that it is never masked. Current-limit pulses are applied in runs of 31 and 32, and also after a window return and during soft-start. These runs show the exact count threshold, the clearing rule and the inhibit rule. Faults applied together, or one after another, expose the override ranking and the held first-cause code.

// File: rtl/fault_guard_pkg.sv
package fault_guard_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_UVLO     = 3'd1,
        ST_RUN      = 3'd2,
        ST_LATCH_CL = 3'd3,
        ST_LATCH_OV = 3'd4,
        ST_LATCH_OT = 3'd5
    } guard_state_e;

    typedef enum logic [2:0] {
        FC_NONE   = 3'd0,
        FC_UVLO   = 3'd1,
        FC_THERM  = 3'd2,
        FC_OV_REL = 3'd3,
        FC_OV_ABS = 3'd4,
        FC_ILIM   = 3'd5
    } fault_code_e;

    typedef struct packed {
        logic top_off;
        logic bot_on;
        logic both_off;
    } drv_override_t;

endpackage

// File: rtl/ilim_pulse_counter.sv
module ilim_pulse_counter #(
    parameter int PULSE_LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en,
    input  logic core_low,
    input  logic trip,
    output logic limit_hit
);
    localparam int CW = $clog2(PULSE_LIMIT + 1);
    localparam logic [CW-1:0] LIMIT_V = CW'(PULSE_LIMIT);

    logic [CW-1:0] cnt;
    logic          trip_q;
    logic          trip_rise;

    assign trip_rise = trip && !trip_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            trip_q <= 1'b0;
        end else begin
            trip_q <= trip;
            if (!count_en) begin
                cnt <= '0;
            end else if (!core_low && !trip) begin
                cnt <= '0;
            end else if (trip_rise && core_low && cnt != LIMIT_V) begin
                cnt <= cnt + CW'(1);
            end
        end
    end

    assign limit_hit = (cnt == LIMIT_V);

    AST_CNT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) cnt <= LIMIT_V); // R3
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) (cnt != $past(cnt)) |-> (cnt == '0 || cnt == $past(cnt) + CW'(1))); // R4

endmodule

// File: rtl/guard_fsm.sv
module guard_fsm
    import fault_guard_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          uvlo,
    input  logic          ss_done,
    input  logic          trans_active,
    input  logic          ovp_rel,
    input  logic          ovp_abs,
    input  logic          over_temp,
    input  logic          cl_hit,
    output logic          running,
    output fault_code_e   code,
    output drv_override_t ovr,
    output logic          latched
);
    guard_state_e state, state_nxt;
    fault_code_e  code_nxt;
    logic         rel_armed;
    logic         ov_any;

    assign rel_armed = ovp_rel && ss_done && !trans_active;
    assign ov_any    = ovp_abs || rel_armed;

    always_comb begin
        state_nxt = state;
        code_nxt  = code;
        if (uvlo) begin
            state_nxt = ST_UVLO;
            code_nxt  = FC_UVLO;
        end else if (!en) begin
            state_nxt = ST_IDLE;
            code_nxt  = FC_NONE;
        end else begin
            unique case (state)
                ST_IDLE, ST_UVLO: begin
                    state_nxt = ST_RUN;
                    code_nxt  = FC_NONE;
                end
                ST_RUN: begin
                    if (over_temp) begin
                        state_nxt = ST_LATCH_OT;
                        code_nxt  = FC_THERM;
                    end else if (ovp_abs) begin
                        state_nxt = ST_LATCH_OV;
                        code_nxt  = FC_OV_ABS;
                    end else if (rel_armed) begin
                        state_nxt = ST_LATCH_OV;
                        code_nxt  = FC_OV_REL;
                    end else if (cl_hit) begin
                        state_nxt = ST_LATCH_CL;
                        code_nxt  = FC_ILIM;
                    end
                end
                ST_LATCH_CL: begin
                    if (over_temp)   state_nxt = ST_LATCH_OT;
                    else if (ov_any) state_nxt = ST_LATCH_OV;
                end
                ST_LATCH_OV: begin
                    if (over_temp) state_nxt = ST_LATCH_OT;
                end
                ST_LATCH_OT: state_nxt = ST_LATCH_OT;
                default: begin
                    state_nxt = ST_IDLE;
                    code_nxt  = FC_NONE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            code  <= FC_NONE;
        end else begin
            state <= state_nxt;
            code  <= code_nxt;
        end
    end

    always_comb begin
        ovr     = '0;
        latched = 1'b0;
        running = 1'b0;
        unique case (state)
            ST_IDLE, ST_UVLO: ovr.both_off = 1'b1;
            ST_RUN:           running = 1'b1;
            ST_LATCH_CL: begin
                ovr.top_off = 1'b1;
                latched     = 1'b1;
            end
            ST_LATCH_OV: begin
                ovr.top_off = 1'b1;
                ovr.bot_on  = 1'b1;
                latched     = 1'b1;
            end
            ST_LATCH_OT: begin
                ovr.both_off = 1'b1;
                latched      = 1'b1;
            end
            default: ovr.both_off = 1'b1;
        endcase
    end

    AST_REL_OV_MASKED: assert property (@(posedge clk) disable iff (!rst_n) (running && en && !uvlo && trans_active && !ovp_abs && !over_temp && !cl_hit) |=> !latched); // R1
    AST_ABS_OV_LATCH: assert property (@(posedge clk) disable iff (!rst_n) (running && en && !uvlo && ovp_abs && !over_temp) |=> (ovr.bot_on && latched)); // R2
    AST_THERMAL_OFF: assert property (@(posedge clk) disable iff (!rst_n) (latched && en && !uvlo && over_temp) |=> (ovr.both_off && !ovr.bot_on && latched)); // R5
    AST_UVLO_OFF: assert property (@(posedge clk) disable iff (!rst_n) uvlo |=> (ovr.both_off && !latched)); // R6
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (latched && en && !uvlo) |=> latched); // R7
    AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n) (latched && $past(latched)) |-> $stable(code)); // R8

endmodule

// File: rtl/fault_guard.sv
module fault_guard
    import fault_guard_pkg::*;
#(
    parameter int ILIM_PULSES = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       uvlo,
    input  logic       ss_done,
    input  logic       trans_active,
    input  logic       ovp_rel,
    input  logic       ovp_abs,
    input  logic       core_low,
    input  logic       ilim_trip,
    input  logic       over_temp,
    output logic [2:0] fault_code,
    output logic       force_top_off,
    output logic       force_bot_on,
    output logic       force_both_off,
    output logic       latched_off
);
    logic          running;
    logic          cl_hit;
    fault_code_e   code;
    drv_override_t ovr;

    ilim_pulse_counter #(
        .PULSE_LIMIT (ILIM_PULSES)
    ) u_ilim_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .count_en  (running && ss_done),
        .core_low  (core_low),
        .trip      (ilim_trip),
        .limit_hit (cl_hit)
    );

    guard_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .en           (en),
        .uvlo         (uvlo),
        .ss_done      (ss_done),
        .trans_active (trans_active),
        .ovp_rel      (ovp_rel),
        .ovp_abs      (ovp_abs),
        .over_temp    (over_temp),
        .cl_hit       (cl_hit),
        .running      (running),
        .code         (code),
        .ovr          (ovr),
        .latched      (latched_off)
    );

    assign fault_code     = code;
    assign force_top_off  = ovr.top_off;
    assign force_bot_on   = ovr.bot_on;
    assign force_both_off = ovr.both_off;

    AST_NO_BOT_WITH_OFF: assert property (@(posedge clk) disable iff (!rst_n) !(force_bot_on && force_both_off)); // R5

endmodule

// File: tb/fault_guard_bench.sv
module fault_guard_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, uvlo = 1'b0, ss_done = 1'b0, trans_active = 1'b0;
    logic ovp_rel = 1'b0, ovp_abs = 1'b0, core_low = 1'b0, ilim_trip = 1'b0, over_temp = 1'b0;
    logic [2:0] fault_code;
    logic force_top_off, force_bot_on, force_both_off, latched_off;
    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    fault_guard u_fault_guard (
        .clk(clk), .rst_n(rst_n), .en(en), .uvlo(uvlo), .ss_done(ss_done),
        .trans_active(trans_active), .ovp_rel(ovp_rel), .ovp_abs(ovp_abs),
        .core_low(core_low), .ilim_trip(ilim_trip), .over_temp(over_temp),
        .fault_code(fault_code), .force_top_off(force_top_off),
        .force_bot_on(force_bot_on), .force_both_off(force_both_off),
        .latched_off(latched_off)
    );

    // {latched, both_off, bot_on, top_off, code}
    localparam logic [6:0] O_RUN    = 7'b0000_000;
    localparam logic [6:0] O_IDLE   = 7'b0100_000;
    localparam logic [6:0] O_UVLO   = 7'b0100_001;
    localparam logic [6:0] O_OT     = 7'b1100_010;
    localparam logic [6:0] O_OV_REL = 7'b1011_011;
    localparam logic [6:0] O_OV_ABS = 7'b1011_100;
    localparam logic [6:0] O_CL     = 7'b1001_101;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input string req, input logic [6:0] exp);
        logic [6:0] obs;
        obs = {latched_off, force_both_off, force_bot_on, force_top_off, fault_code};
        checks++;
        if (obs !== exp) begin
            fails++;
            $display("FAIL %s: actual=%b expected=%b", req, obs, exp);
        end
    endtask

    task automatic clear_inputs();
        uvlo = 0; ovp_rel = 0; ovp_abs = 0; core_low = 0; ilim_trip = 0;
        over_temp = 0; trans_active = 0; ss_done = 1;
    endtask

    task automatic restart();
        clear_inputs();
        en = 0;
        tick(2);
        en = 1;
        tick(2);
        expect_out("R7 restart to run", O_RUN);
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ilim_trip = 1; tick(1);
            ilim_trip = 0; tick(1);
        end
    endtask

    task automatic t_reset();
        tick(2);
        expect_out("R9 reset state", O_IDLE);
    endtask

    task automatic t_rel_ov();
        restart();
        ss_done = 0; ovp_rel = 1; tick(3);
        expect_out("R1 rel ov masked in soft-start", O_RUN);
        ss_done = 1; trans_active = 1; tick(3);
        expect_out("R1 rel ov masked in transition", O_RUN);
        trans_active = 0; tick(1);
        expect_out("R1 rel ov latch", O_OV_REL);
    endtask

    task automatic t_abs_ov();
        restart();
        ss_done = 0; trans_active = 1; ovp_abs = 1; tick(1);
        expect_out("R2 abs ov during transition", O_OV_ABS);
    endtask

    task automatic t_ilim_count();
        restart();
        core_low = 1;
        pulses(31); tick(2);
        expect_out("R3 31 pulses no latch", O_RUN);
        pulses(1); tick(1);
        expect_out("R3 32nd pulse latches", O_CL);
    endtask

    task automatic t_ilim_clear();
        restart();
        core_low = 1;
        pulses(20);
        core_low = 0; tick(1);
        core_low = 1;
        pulses(31); tick(2);
        expect_out("R4 window return clears count", O_RUN);
        ss_done = 0;
        pulses(40); tick(2);
        expect_out("R4 no counting in soft-start", O_RUN);
        ss_done = 1;
        pulses(31); tick(2);
        expect_out("R4 count restarts after soft-start", O_RUN);
        pulses(1); tick(1);
        expect_out("R4 latch after 32 armed pulses", O_CL);
    endtask

    task automatic t_thermal();
        restart();
        over_temp = 1; tick(1);
        expect_out("R5 thermal latch", O_OT);
        over_temp = 0; tick(5);
        expect_out("R7 thermal latch persists", O_OT);
        uvlo = 1; tick(1);
        expect_out("R6 uvlo clears latch", O_UVLO);
        tick(3);
        expect_out("R6 uvlo held not latched", O_UVLO);
        uvlo = 0; tick(2);
        expect_out("R6 uvlo release to run", O_RUN);
    endtask

    task automatic t_clear_by_en();
        restart();
        ovp_abs = 1; tick(1);
        ovp_abs = 0; tick(6);
        expect_out("R7 ov latch persists", O_OV_ABS);
        en = 0; tick(1);
        expect_out("R7 enable low clears", O_IDLE);
        en = 1; tick(2);
        expect_out("R7 re-enable runs", O_RUN);
    endtask

    task automatic t_priority();
        restart();
        over_temp = 1; ovp_abs = 1; ovp_rel = 1; tick(1);
        expect_out("R8 thermal beats ov", O_OT);
        restart();
        ovp_abs = 1; ovp_rel = 1; tick(1);
        expect_out("R8 abs beats rel", O_OV_ABS);
        restart();
        core_low = 1; pulses(32); tick(1);
        expect_out("R8 cl latched first", O_CL);
        ovp_rel = 1; tick(1);
        expect_out("R8 ov overrides cl, code kept", 7'b1011_101);
        over_temp = 1; tick(1);
        expect_out("R8 thermal overrides ov, code kept", 7'b1100_101);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog: actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        @(negedge clk);
        rst_n = 1;
        t_rel_ov();
        t_abs_ov();
        t_ilim_count();
        t_ilim_clear();
        t_thermal();
        t_clear_by_en();
        t_priority();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule